// File: doc/BRIEF.md
# GPIO Bank with Edge and Level Interrupt Masking

This block is a bank of general-purpose pins behind a small word-addressed register port. Software can drive each pin with a registered data value, or release it to act as an input. The output enable is active-low. A pin can blink its driven value at a fixed rate. Each input can be inverted by a per-pin polarity bit before anything else looks at it.

Raw pin levels pass through a two-flop synchronizer. They are then XORed with the polarity bits, giving the data-in value that both software and the interrupt logic see. A rising transition of data-in latches a sticky cause bit. Software clears cause bits by writing zeros to them. A single interrupt line combines two sources: cause bits gated by the edge mask, and live data-in bits gated by the level mask.

Register map (byte offsets, word aligned): 0x00 data-out, 0x04 output-enable (active-low), 0x08 blink-enable, 0x0C polarity, 0x10 data-in (read-only), 0x14 cause, 0x18 edge mask, 0x1C level mask.

Top module: `gpio_bank`

## Requirements
- R1: Reset state:
  - the edge mask, level mask, cause, data-out, blink and polarity registers are all zero;
  - the output-enable register is all ones, so every pin is an input and `pin_oe_n` is all ones;
  - `pin_out` is zero and `irq` is low.
- R2: `pin_oe_n` equals the output-enable register and shows a write from the edge after it is written. A 0 bit drives the pin and a 1 bit makes it an input. The register reads back unchanged at 0x04.
- R3: Reading 0x10 returns the pin levels XORed with the polarity register. A pin change is visible after two rising clock edges and not after one.
- R4: A 0-to-1 transition of a data-in bit sets that bit's cause bit, which then stays set after the input falls. This includes a transition caused by a polarity write.
- R5: A write to 0x14 clears every cause bit whose write-data bit is 0 and keeps every bit whose write-data bit is 1. An all-zero write clears all of them.
- R6: When a rising data-in transition and a clearing write to 0x14 meet in the same cycle, the cause bit ends up set.
- R7: `irq` is high exactly when (cause AND edge mask) OR (data-in AND level mask) is nonzero. With both masks zero, it stays low whatever the cause bits are.
- R8: Edge mask and level mask registers:
  - the edge mask sits at 0x18 and the level mask at 0x1C, and each reads back what was written;
  - an access whose two low address bits are not 00 writes nothing and reads 0.
- R9: For a pin whose blink bit is 0, `pin_out` follows its data-out bit one edge after the write. For a pin whose blink bit is 1, `pin_out` inverts once every BLINK_HALF clock cycles.
- R10: Writes to the data-in offset 0x10 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | NPINS | Write data, one bit per pin |
| bus_rdata | output | NPINS | Read data for `bus_addr`, combinational |
| pin_in | input | NPINS | Raw pin levels, asynchronous |
| pin_out | output | NPINS | Registered value driven to each pad |
| pin_oe_n | output | NPINS | Active-low output enable per pad |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume a few things about the inputs:
- `rst` is held for at least one edge before normal traffic starts;
- `pin_in` is low while reset is applied, so no spurious rise is seen when reset ends;
- bus writes are single-cycle strobes with stable address and data.

The stimulus follows these assumptions. It changes every input on the falling edge, away from the active edge. It keeps pins low during reset. It waits at least three edges after any pin or polarity change before judging cause or interrupt state. The one exception is the set-versus-clear test, which deliberately places the clearing write on the exact edge that latches the rise.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int unsigned ADDR_W = 5;

    // Word index decoded from bus_addr[4:2]
    typedef enum logic [2:0] {
        REG_DOUT  = 3'd0,
        REG_OEN   = 3'd1,
        REG_BLINK = 3'd2,
        REG_POL   = 3'd3,
        REG_DIN   = 3'd4,
        REG_CAUSE = 3'd5,
        REG_EDGE  = 3'd6,
        REG_LEVEL = 3'd7
    } reg_sel_e;

    function automatic logic addr_aligned(input logic [ADDR_W-1:0] a);
        return a[1:0] == 2'b00;
    endfunction

    function automatic reg_sel_e addr_sel(input logic [ADDR_W-1:0] a);
        return reg_sel_e'(a[ADDR_W-1:2]);
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned NPINS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] pol,
    output logic [NPINS-1:0] din,
    output logic [NPINS-1:0] rise
);
    logic [NPINS-1:0] meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
            prev_q <= din;
        end
    end

    assign din  = sync_q ^ pol;
    assign rise = din & ~prev_q;

endmodule

// File: rtl/gpio_blink_gen.sv
module gpio_blink_gen #(
    parameter int unsigned NPINS      = 32,
    parameter int unsigned BLINK_HALF = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] dout,
    input  logic [NPINS-1:0] blink_en,
    output logic [NPINS-1:0] pin_out
);
    localparam int unsigned CW = (BLINK_HALF > 1) ? $clog2(BLINK_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(BLINK_HALF - 1);

    logic [CW-1:0] cnt_q;
    logic          phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
            pin_out <= '0;
        end else begin
            if (cnt_q == LAST) begin
                cnt_q   <= '0;
                phase_q <= ~phase_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
            pin_out <= dout ^ (blink_en & {NPINS{phase_q}});
        end
    end

    assert_cnt_range_R9: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) < int'(BLINK_HALF));

    assert_plain_out_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |->
        ((pin_out & ~$past(blink_en)) == ($past(dout) & ~$past(blink_en))));

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
    parameter int unsigned NPINS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] rise,
    input  logic [NPINS-1:0] din,
    input  logic             clr_we,
    input  logic [NPINS-1:0] clr_keep,
    input  logic [NPINS-1:0] edge_m,
    input  logic [NPINS-1:0] lvl_m,
    output logic [NPINS-1:0] cause,
    output logic             irq
);
    logic [NPINS-1:0] kept;

    assign kept = clr_we ? (cause & clr_keep) : cause;

    always_ff @(posedge clk) begin
        if (rst) cause <= '0;
        else     cause <= kept | rise;
    end

    assign irq = |((cause & edge_m) | (din & lvl_m));

    assert_cause_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        !clr_we |=> ((cause & $past(cause)) == $past(cause)));

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
        (|rise) |=> ((cause & $past(rise)) == $past(rise)));

    assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (edge_m == '0 && lvl_m == '0) |-> !irq);

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NPINS      = 32,
    parameter int unsigned BLINK_HALF = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe_n,
    output logic              irq
);
    logic [NPINS-1:0] dout_q, oen_q, blink_q, pol_q, edge_q, lvl_q;
    logic [NPINS-1:0] din, rise, cause;
    logic             wr_ok, clr_we;
    reg_sel_e         sel;

    assign sel    = addr_sel(bus_addr);
    assign wr_ok  = bus_we && addr_aligned(bus_addr);
    assign clr_we = wr_ok && (sel == REG_CAUSE);

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q  <= '0;
            oen_q   <= '1;
            blink_q <= '0;
            pol_q   <= '0;
            edge_q  <= '0;
            lvl_q   <= '0;
        end else if (wr_ok) begin
            case (sel)
                REG_DOUT:  dout_q  <= bus_wdata;
                REG_OEN:   oen_q   <= bus_wdata;
                REG_BLINK: blink_q <= bus_wdata;
                REG_POL:   pol_q   <= bus_wdata;
                REG_EDGE:  edge_q  <= bus_wdata;
                REG_LEVEL: lvl_q   <= bus_wdata;
                default:   ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (addr_aligned(bus_addr)) begin
            case (sel)
                REG_DOUT:  bus_rdata = dout_q;
                REG_OEN:   bus_rdata = oen_q;
                REG_BLINK: bus_rdata = blink_q;
                REG_POL:   bus_rdata = pol_q;
                REG_DIN:   bus_rdata = din;
                REG_CAUSE: bus_rdata = cause;
                REG_EDGE:  bus_rdata = edge_q;
                REG_LEVEL: bus_rdata = lvl_q;
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign pin_oe_n = oen_q;

    gpio_in_sync #(.NPINS(NPINS)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_in (pin_in),
        .pol    (pol_q),
        .din    (din),
        .rise   (rise)
    );

    gpio_irq_unit #(.NPINS(NPINS)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .rise     (rise),
        .din      (din),
        .clr_we   (clr_we),
        .clr_keep (bus_wdata),
        .edge_m   (edge_q),
        .lvl_m    (lvl_q),
        .cause    (cause),
        .irq      (irq)
    );

    gpio_blink_gen #(.NPINS(NPINS), .BLINK_HALF(BLINK_HALF)) u_blink (
        .clk      (clk),
        .rst      (rst),
        .dout     (dout_q),
        .blink_en (blink_q),
        .pin_out  (pin_out)
    );

    assert_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (edge_q == '0 && lvl_q == '0 && pin_oe_n == '1 && !irq));

    assert_oe_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !(wr_ok && sel == REG_OEN) |=> $stable(pin_oe_n));

endmodule

// File: tb/gpio_bank_tb.sv
`timescale 1ns/1ps
module gpio_bank_tb;
    localparam int HALF = 8;

    localparam logic [4:0] A_DOUT  = 5'h00;
    localparam logic [4:0] A_OEN   = 5'h04;
    localparam logic [4:0] A_BLINK = 5'h08;
    localparam logic [4:0] A_POL   = 5'h0C;
    localparam logic [4:0] A_DIN   = 5'h10;
    localparam logic [4:0] A_CAUSE = 5'h14;
    localparam logic [4:0] A_EDGE  = 5'h18;
    localparam logic [4:0] A_LEVEL = 5'h1C;

    // {pin levels, polarity, expected data-in}
    localparam logic [95:0] VECS [0:3] = '{
        {32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
        {32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF},
        {32'hA5A5_0F0F, 32'hFFFF_0000, 32'h5A5A_0F0F},
        {32'h1234_5678, 32'h0F0F_0F0F, 32'h1D3B_5977}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe_n;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    gpio_bank #(.NPINS(32), .BLINK_HALF(HALF)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe_n  (pin_oe_n),
        .irq       (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] r, a, b;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        bus_read(A_EDGE, r);  check("R1 edge mask", r, 32'h0);
        bus_read(A_LEVEL, r); check("R1 level mask", r, 32'h0);
        bus_read(A_CAUSE, r); check("R1 cause", r, 32'h0);
        bus_read(A_OEN, r);   check("R1 oe reg", r, 32'hFFFF_FFFF);
        check("R1 pin_oe_n", pin_oe_n, 32'hFFFF_FFFF);
        check("R1 pin_out", pin_out, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R2 output enable
        bus_write(A_OEN, 32'h0000_FF00);
        check("R2 pin_oe_n", pin_oe_n, 32'h0000_FF00);
        bus_read(A_OEN, r); check("R2 readback", r, 32'h0000_FF00);

        // R8 mask offsets and alignment
        bus_write(A_EDGE, 32'h11);
        bus_write(A_LEVEL, 32'h22);
        bus_read(A_EDGE, r);  check("R8 edge at 0x18", r, 32'h11);
        bus_read(A_LEVEL, r); check("R8 level at 0x1C", r, 32'h22);
        bus_write(5'h19, 32'hFFFF);
        bus_read(A_EDGE, r);  check("R8 misaligned write ignored", r, 32'h11);
        bus_read(5'h19, r);   check("R8 misaligned read zero", r, 32'h0);
        bus_write(A_EDGE, 32'h0);
        bus_write(A_LEVEL, 32'h0);

        // R3 table of pin / polarity patterns
        for (int i = 0; i < 4; i++) begin
            bus_write(A_POL, VECS[i][63:32]);
            pin_in = VECS[i][95:64];
            settle();
            bus_read(A_DIN, r);
            check($sformatf("R3 vector %0d", i), r, VECS[i][31:0]);
        end
        bus_write(A_POL, 32'h0);
        pin_in = 32'h0;
        settle();
        bus_write(A_CAUSE, 32'h0);
        bus_read(A_CAUSE, r); check("R5 all-zero write clears", r, 32'h0);

        // R3 two-edge latency
        @(negedge clk); pin_in = 32'h4;
        @(negedge clk); bus_addr = A_DIN; #1 check("R3 not after one edge", bus_rdata, 32'h0);
        @(negedge clk); #1 check("R3 after two edges", bus_rdata, 32'h4);

        // R10 data-in is read-only
        bus_write(A_DIN, 32'h0);
        bus_read(A_DIN, r); check("R10 write ignored", r, 32'h4);

        // R4 rising edges set sticky causes
        settle();
        bus_write(A_CAUSE, 32'h0);
        bus_read(A_CAUSE, r); check("R4 clean start", r, 32'h0);
        pin_in = 32'hC; settle();
        bus_read(A_CAUSE, r); check("R4 rise sets bit 3", r, 32'h8);
        pin_in = 32'h4; settle();
        bus_read(A_CAUSE, r); check("R4 sticky after fall", r, 32'h8);
        bus_write(A_POL, 32'h2); settle();
        bus_read(A_CAUSE, r); check("R4 polarity edge", r, 32'hA);

        // R5 selective clear
        bus_write(A_CAUSE, 32'hFFFF_FFF7);
        bus_read(A_CAUSE, r); check("R5 clear bit 3 only", r, 32'h2);
        bus_write(A_CAUSE, 32'h0);
        bus_read(A_CAUSE, r); check("R5 clear all", r, 32'h0);

        // R6 set wins over a clear in the same cycle
        pin_in = 32'h14; settle();
        bus_read(A_CAUSE, r); check("R6 precondition", r, 32'h10);
        @(negedge clk); pin_in = 32'h214;
        @(negedge clk);
        @(negedge clk); bus_we = 1'b1; bus_addr = A_CAUSE; bus_wdata = 32'h0;
        @(negedge clk); bus_we = 1'b0;
        bus_read(A_CAUSE, r); check("R6 set wins", r, 32'h200);

        // R7 interrupt combining
        check("R7 masks zero keep irq low", {31'b0, irq}, 32'h0);
        bus_write(A_EDGE, 32'h200);
        check("R7 edge source", {31'b0, irq}, 32'h1);
        bus_write(A_CAUSE, 32'h0);
        check("R7 cleared edge source", {31'b0, irq}, 32'h0);
        bus_write(A_EDGE, 32'h0);
        bus_write(A_LEVEL, 32'h80);
        pin_in = 32'h294; settle();
        check("R7 level source high", {31'b0, irq}, 32'h1);
        pin_in = 32'h214; settle();
        check("R7 level source low", {31'b0, irq}, 32'h0);
        bus_write(A_POL, 32'h82); settle();
        check("R7 level via polarity", {31'b0, irq}, 32'h1);
        bus_write(A_LEVEL, 32'h0);

        // R9 plain output latency
        bus_write(A_DOUT, 32'h0000_00C0);
        check("R9 not before edge", pin_out, 32'h0);
        @(negedge clk); check("R9 after one edge", pin_out, 32'h0000_00C0);

        // R9 blinking pins
        bus_write(A_BLINK, 32'h0000_0030);
        bus_write(A_DOUT, 32'h0000_00F0);
        settle();
        a = pin_out;
        repeat (HALF) @(negedge clk);
        b = pin_out;
        check("R9 blink toggles once per half", a ^ b, 32'h0000_0030);
        check("R9 steady bits", b & 32'hFFFF_FFCF, 32'h0000_00C0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule